// File: doc/BRIEF.md
# Character LCD I2C Power-Up Sequencer

This block runs on the host side of a character LCD controller. After the controller leaves reset, the block sends it the fixed set of configuration instructions it needs before it can display anything. The block does not drive the I2C wires itself. It hands bytes, one at a time, to a byte-level I2C master engine through a request/response port. Each request can ask the engine to put a START condition before the byte or a STOP condition after it.

Every instruction travels in its own write transaction of three bytes. The first is the slave address with the write bit clear. The second is a control byte of zero, which marks the next byte as a command. The third is the instruction itself. After each instruction the block waits a fixed number of clock cycles, because this interface has no busy flag to poll. The wait after the final clear-display instruction is longer than the others. Three instructions (contrast, power/contrast and follower) change value with the supply voltage, which is chosen by an input. A 2-bit input picks one of four neighbouring slave addresses. If any byte is not acknowledged, the block stops and flags an error. When all instructions have been sent, it raises a done flag.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset, `busReq`, `done` and `error` are all low, and no request is issued until a start pulse arrives.
- R2: If `start` is sampled high while the block is idle, the first byte request (`busReq` high for one cycle with `busStart` high) appears in the very next cycle. The same edge clears `done` and `error`.
- R3: Each instruction is a transaction of three requests in this order: the address byte with `busStart`=1; the control byte 0x00 with both flags low; the instruction byte with `busStop`=1. After an acknowledged `busDone` for the address or control byte, the next request comes in the following cycle. Only one request is outstanding at a time.
- R4: The instruction bytes are sent in this order: 0x38, 0x39, 0x14, contrast, power/contrast, follower, 0x0C, 0x01.
- R5: With `supplyHigh`=0, contrast is 0x74, power/contrast is 0x54 and follower is 0x6F. With `supplyHigh`=1, the values are 0x79, 0x50 and 0x6C. `supplyHigh` is sampled only at start; later changes have no effect on the running sequence.
- R6: The address byte is {SLAVE_BASE + `addrSel`, 1'b0}, which with the default SLAVE_BASE=0x3C gives 0x78, 0x7A, 0x7C or 0x7E. `addrSel` is sampled only at start.
- R7: After an acknowledged `busDone` for the instruction byte, the next address request comes WAIT_CMD cycles later. After the clear-display instruction, `done` rises WAIT_CLR cycles later.
- R8: If `busDone` arrives with `busAck`=0, `error` rises in the next cycle, no further requests are issued, and `done` stays low.
- R9: A start pulse that arrives while the sequence is running is ignored. The running sequence goes on unchanged and is not restarted afterwards.
- R10: `done` and `error` are never high together. Each stays high until the next accepted start, and a new start is accepted after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (accepted only when idle) |
| supplyHigh | input | 1 | 1 selects the high-voltage constants, 0 the low-voltage ones |
| addrSel | input | 2 | Offset added to SLAVE_BASE to form the slave address |
| busReq | output | 1 | One-cycle request to the engine to transfer `busByte` |
| busByte | output | 8 | Byte to transmit; valid while `busReq` is high |
| busStart | output | 1 | Engine issues START before this byte |
| busStop | output | 1 | Engine issues STOP after this byte |
| busDone | input | 1 | One-cycle pulse from the engine: the byte and its ACK slot are finished |
| busAck | input | 1 | ACK result, valid with `busDone` (1 = acknowledged) |
| done | output | 1 | Every instruction sent and every wait elapsed |
| error | output | 1 | A byte was not acknowledged; the sequence was aborted |

## Verification
All results of this block come one edge after the event that causes them, plus any programmed wait:

- **Start to first request:** the first request shows up in the cycle right after the edge that samples `start`.
- **Byte to next byte:** within a transaction, the next byte follows the edge that samples an acknowledged `busDone`.
- **Error:** `error` rises one cycle after a not-acknowledged `busDone`.
- **Instruction gaps:** the next address request, or `done`, arrives exactly WAIT_CMD or WAIT_CLR edges after the edge that samples the instruction byte's `busDone`.

The bench captures the inputs at each rising edge. On the following falling edge it advances a behavioural model by one step and compares every output with the model, so each result is checked in exactly the cycle it is due. The engine model answers with varying latencies, which moves these timings around across the runs.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int NUM_CMDS = 8;
  localparam int CMD_W = $clog2(NUM_CMDS);
  localparam int BYTES_PER_CMD = 3;
  localparam logic [7:0] CTRL_CMD = 8'h00;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DELAY
  } seqStateT;

  typedef struct packed {
    logic clrSeq;
    logic nextByte;
    logic nextCmd;
    logic ldWait;
    logic decWait;
  } seqStrobeT;

  function automatic logic [7:0] initCmd(input logic [CMD_W-1:0] idx, input logic hi);
    logic [7:0] v;
    case (idx)
      3'd0:    v = 8'h38;
      3'd1:    v = 8'h39;
      3'd2:    v = 8'h14;
      3'd3:    v = hi ? 8'h79 : 8'h74;
      3'd4:    v = hi ? 8'h50 : 8'h54;
      3'd5:    v = hi ? 8'h6C : 8'h6F;
      3'd6:    v = 8'h0C;
      default: v = 8'h01;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/lcd_init_dp.sv
module lcd_init_dp
  import lcd_init_pkg::*;
#(
  parameter logic [6:0] SLAVE_BASE = 7'h3C,
  parameter int WAIT_CMD = 40,
  parameter int WAIT_CLR = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobeT  stb,
  input  logic       supplyHigh,
  input  logic [1:0] addrSel,
  output logic [7:0] busByte,
  output logic       busStart,
  output logic       busStop,
  output logic       lastByte,
  output logic       lastCmd,
  output logic       waitOne
);

  localparam int MAX_WAIT = (WAIT_CMD > WAIT_CLR) ? WAIT_CMD : WAIT_CLR;
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);
  localparam int BIDX_W = $clog2(BYTES_PER_CMD);

  logic [CMD_W-1:0]  cmdIdx;
  logic [BIDX_W-1:0] byteIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic              cfgHi;
  logic [1:0]        cfgSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdIdx  <= '0;
      byteIdx <= '0;
      waitCnt <= '0;
      cfgHi   <= 1'b0;
      cfgSel  <= '0;
    end else begin
      if (stb.clrSeq) begin
        cmdIdx  <= '0;
        byteIdx <= '0;
        cfgHi   <= supplyHigh;
        cfgSel  <= addrSel;
      end
      if (stb.nextByte) byteIdx <= byteIdx + 1'b1;
      if (stb.nextCmd) begin
        cmdIdx  <= cmdIdx + 1'b1;
        byteIdx <= '0;
      end
      if (stb.ldWait) waitCnt <= lastCmd ? WAIT_W'(WAIT_CLR) : WAIT_W'(WAIT_CMD);
      else if (stb.decWait) waitCnt <= waitCnt - 1'b1;
    end
  end

  always_comb begin
    case (byteIdx)
      BIDX_W'(0): busByte = {SLAVE_BASE + 7'(cfgSel), 1'b0};
      BIDX_W'(1): busByte = CTRL_CMD;
      default:    busByte = initCmd(cmdIdx, cfgHi);
    endcase
  end

  assign busStart = (byteIdx == BIDX_W'(0));
  assign busStop  = (byteIdx == BIDX_W'(BYTES_PER_CMD - 1));
  assign lastByte = busStop;
  assign lastCmd  = (cmdIdx == CMD_W'(NUM_CMDS - 1));
  assign waitOne  = (waitCnt == WAIT_W'(1));

  // R6: a framed address byte always carries a write bit and an in-range address
  a_r6_addr_frame: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> (busByte[0] == 1'b0 && (busByte[7:1] - SLAVE_BASE) < 7'd4));

  // R3: the byte index never leaves the three-byte frame
  a_r3_frame_bound: assert property (@(posedge clk) disable iff (!rstN)
    stb.nextByte |-> !lastByte);

  // R7: a wait counter is only counted down while it is above one
  a_r7_wait_floor: assert property (@(posedge clk) disable iff (!rstN)
    stb.decWait |-> waitCnt > WAIT_W'(1));

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      busDone,
  input  logic      busAck,
  input  logic      lastByte,
  input  logic      lastCmd,
  input  logic      waitOne,
  output seqStrobeT stb,
  output logic      busReq,
  output logic      done,
  output logic      error
);

  seqStateT state, stateNxt;
  logic doneNxt, errorNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    doneNxt  = done;
    errorNxt = error;
    case (state)
      S_IDLE: if (start) begin
        stb.clrSeq = 1'b1;
        doneNxt    = 1'b0;
        errorNxt   = 1'b0;
        stateNxt   = S_ISSUE;
      end
      S_ISSUE: stateNxt = S_WAIT;
      S_WAIT: if (busDone) begin
        if (!busAck) begin
          errorNxt = 1'b1;
          stateNxt = S_IDLE;
        end else if (!lastByte) begin
          stb.nextByte = 1'b1;
          stateNxt     = S_ISSUE;
        end else begin
          stb.ldWait = 1'b1;
          stateNxt   = S_DELAY;
        end
      end
      S_DELAY: if (waitOne) begin
        if (lastCmd) begin
          doneNxt  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          stb.nextCmd = 1'b1;
          stateNxt    = S_ISSUE;
        end
      end else begin
        stb.decWait = 1'b1;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
      error <= errorNxt;
    end
  end

  assign busReq = (state == S_ISSUE);

  // R3: one request at a time, never back to back
  a_r3_single_req: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> !busReq);

  // R8: an unacknowledged byte ends the sequence with error
  a_r8_nack_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && busDone && !busAck) |=> (error && !busReq && !done));

  // R10: the two completion flags are exclusive
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R9: while a sequence runs, a start pulse cannot bring back idle flags
  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && start) |=> (state != S_IDLE || done || error));

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter logic [6:0] SLAVE_BASE = 7'h3C,
  parameter int WAIT_CMD = 40,
  parameter int WAIT_CLR = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       supplyHigh,
  input  logic [1:0] addrSel,
  output logic       busReq,
  output logic [7:0] busByte,
  output logic       busStart,
  output logic       busStop,
  input  logic       busDone,
  input  logic       busAck,
  output logic       done,
  output logic       error
);

  seqStrobeT stb;
  logic lastByte, lastCmd, waitOne;

  lcd_init_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .busDone(busDone), .busAck(busAck),
    .lastByte(lastByte), .lastCmd(lastCmd), .waitOne(waitOne),
    .stb(stb), .busReq(busReq), .done(done), .error(error)
  );

  lcd_init_dp #(
    .SLAVE_BASE(SLAVE_BASE), .WAIT_CMD(WAIT_CMD), .WAIT_CLR(WAIT_CLR)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .supplyHigh(supplyHigh), .addrSel(addrSel),
    .busByte(busByte), .busStart(busStart), .busStop(busStop),
    .lastByte(lastByte), .lastCmd(lastCmd), .waitOne(waitOne)
  );

endmodule

// File: tb/sim_lcd_init_seq.sv
module sim_lcd_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CMD = 12;
  localparam int WAIT_CLR = 60;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, supplyHigh = 1'b0;
  logic [1:0] addrSel = 2'd0;
  logic busReq, busStart, busStop, done, error;
  logic [7:0] busByte;
  logic busDone = 1'b0, busAck = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_init_seq #(.WAIT_CMD(WAIT_CMD), .WAIT_CLR(WAIT_CLR)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .supplyHigh(supplyHigh), .addrSel(addrSel),
    .busReq(busReq), .busByte(busByte), .busStart(busStart), .busStop(busStop),
    .busDone(busDone), .busAck(busAck), .done(done), .error(error)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] specCmd(input int i, input bit hi);
    case (i)
      0: return 8'h38;
      1: return 8'h39;
      2: return 8'h14;
      3: return hi ? 8'h79 : 8'h74;
      4: return hi ? 8'h50 : 8'h54;
      5: return hi ? 8'h6C : 8'h6F;
      6: return 8'h0C;
      default: return 8'h01;
    endcase
  endfunction

  // inputs as seen by the design at the last rising edge
  logic sStart = 0, sDone = 0, sAck = 1, sHi = 0;
  logic [1:0] sSel = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    sStart <= start; sDone <= busDone; sAck <= busAck; sHi <= supplyHigh; sSel <= addrSel;
  end

  // reference model state
  bit mRun = 0, mDone = 0, mErr = 0, mReq;
  int mWait = 0;
  logic [9:0] mQ[$];
  logic [9:0] mCur = '0;
  bit modelOn = 0;

  // engine model and logs
  int engLat = 2, engCnt = 0, nackAt = -1, reqOrd = 0;
  bit ackNext = 1;
  int reqCount = 0;
  logic [7:0] firstAddr = '0;
  logic [7:0] instrLog[$];

  always @(negedge clk) begin
    if (modelOn) begin
      mReq = 0;
      if (!mRun && sStart) begin
        mQ.delete();
        for (int i = 0; i < 8; i++) begin
          mQ.push_back({1'b1, 1'b0, 7'h3C + 7'(sSel), 1'b0});
          mQ.push_back({2'b00, 8'h00});
          mQ.push_back({1'b0, 1'b1, specCmd(i, sHi)});
        end
        mRun = 1; mDone = 0; mErr = 0; mReq = 1;
      end else if (mRun && mWait > 0) begin
        mWait--;
        if (mWait == 0) begin
          if (mQ.size() == 0) begin mDone = 1; mRun = 0; end
          else mReq = 1;
        end
      end else if (mRun && sDone) begin
        if (!sAck) begin mErr = 1; mRun = 0; mQ.delete(); end
        else if (mCur[8]) mWait = (mQ.size() == 0) ? WAIT_CLR : WAIT_CMD;
        else mReq = 1;
      end
      chk(busReq == mReq, "R2/R3/R7 busReq timing", busReq, mReq);
      if (mReq && mQ.size() > 0) begin
        mCur = mQ.pop_front();
        chk(busByte == mCur[7:0], "R4/R5/R6 busByte", busByte, mCur[7:0]);
        chk({busStart, busStop} == mCur[9:8], "R3 start/stop flags", {busStart, busStop}, mCur[9:8]);
      end
      chk(done == mDone, "R7/R10 done", done, mDone);
      chk(error == mErr, "R8 error", error, mErr);

      // engine
      busDone = 0;
      if (engCnt > 0) begin
        engCnt--;
        if (engCnt == 0) begin busDone = 1; busAck = ackNext; end
      end
      if (busReq) begin
        engCnt = engLat;
        ackNext = (reqOrd != nackAt);
        reqOrd++;
        if (reqCount == 0) firstAddr = busByte;
        if (busStop) instrLog.push_back(busByte);
        reqCount++;
      end
    end
  end

  task automatic launch(input bit hi, input logic [1:0] sel, input int lat, input int nack);
    supplyHigh = hi; addrSel = sel; engLat = lat; nackAt = nack; reqOrd = 0;
    reqCount = 0; instrLog.delete();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    while (!done && !error && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic checkList(input bit hi, input logic [1:0] sel, input string tag);
    chk(reqCount == 24, "R3 request count", reqCount, 24);
    chk(firstAddr == {7'h3C + 7'(sel), 1'b0}, "R6 address byte", firstAddr, {7'h3C + 7'(sel), 1'b0});
    chk(instrLog.size() == 8, "R4 instruction count", instrLog.size(), 8);
    for (int i = 0; i < 8 && i < instrLog.size(); i++)
      chk(instrLog[i] == specCmd(i, hi), tag, instrLog[i], specCmd(i, hi));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busReq == 0, "R1 busReq after reset", busReq, 0);
    chk(done == 0, "R1 done after reset", done, 0);
    chk(error == 0, "R1 error after reset", error, 0);
    rstN = 1'b1;
    modelOn = 1;
    repeat (5) @(negedge clk);
    chk(busReq == 0, "R1 no request without start", busReq, 0);

    // low supply, address 0x3C, engine latency 3
    launch(1'b0, 2'd0, 3, -1);
    waitEnd();
    chk(done == 1, "R10 done after low-supply run", done, 1);
    checkList(1'b0, 2'd0, "R4/R5 low-supply instruction");
    repeat (20) @(negedge clk);
    chk(done == 1, "R10 done held", done, 1);

    // high supply, address 0x3F, latency 1, start pulse and input changes mid-run
    launch(1'b1, 2'd3, 1, -1);
    repeat (30) @(negedge clk);
    supplyHigh = 1'b0; addrSel = 2'd1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitEnd();
    chk(done == 1, "R9 done after mid-run start", done, 1);
    checkList(1'b1, 2'd3, "R5 high-supply instruction (inputs latched)");
    repeat (WAIT_CLR + 20) @(negedge clk);
    chk(reqCount == 24, "R9 no restart after ignored start", reqCount, 24);

    // NACK on the control byte of the second instruction
    launch(1'b0, 2'd2, 2, 4);
    waitEnd();
    chk(error == 1, "R8 error after nack", error, 1);
    chk(done == 0, "R8 done low after nack", done, 0);
    repeat (50) @(negedge clk);
    chk(reqCount == 5, "R8 no requests after nack", reqCount, 5);

    // NACK on the very first address byte
    launch(1'b1, 2'd1, 4, 0);
    waitEnd();
    chk(error == 1, "R8 error on address nack", error, 1);
    chk(reqCount == 1, "R8 single request before abort", reqCount, 1);

    // restart after error
    launch(1'b1, 2'd1, 2, -1);
    repeat (2) @(negedge clk);
    chk(error == 0, "R10 error cleared by start", error, 0);
    waitEnd();
    chk(done == 1, "R10 done after restart", done, 1);
    checkList(1'b1, 2'd1, "R4/R5 restart instruction");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule